// File: doc/BRIEF.md
# Double-Data-Rate Read Burst Sequencer

This block is the device-side read path of a double-data-rate synchronous memory. A command port takes READ commands, each with a bank and a column address, and BURST STOP commands. Each READ produces a burst of data beats after a CAS latency that is chosen per command. The beats leave on two data buses, one for the rising half of the clock and one for the falling half, together with a per-half valid flag and a drive-enable flag. The valid flag stands in for the data strobe and the drive-enable for the tri-state control of the pins.

A READ that arrives while an earlier burst is running, or is still waiting to start, cuts that burst short. The earlier burst keeps driving until the cycle in which the new burst is due. From that cycle the new READ sends a full-length burst at its own address, and the unsent beats of the old burst are dropped. A BURST STOP takes effect after the same latency and turns the data drivers off, which frees the bus for a later write. Read data comes from a fixed pattern derived from the bank and column, so the block needs no storage array.

Top module: `ddrrd_seq`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `beatValid` is 0, `driveEn` is 0 and both data buses are 0.
- R2: A READ sampled in cycle t sends its first beat pair in cycle t+CL. CL is taken from `casLat` with that command: code 3 means CL 3, and codes 0, 1 and 2 mean CL 2.
- R3: Each output cycle of a burst carries two beats. `doutRise` holds beat 2j and `doutFall` holds beat 2j+1. In that cycle `beatValid` is 2'b11 and `driveEn` is 1.
- R4: Burst length BL is taken from `blSel` with each command: 0 means 2, 1 means 4, and 2 or 3 mean 8. A burst that is not cut off fills BL/2 consecutive cycles.
- R5: Beat k of a burst reads column (col & ~(BL-1)) | ((col + k) mod BL). The address wraps inside the BL-aligned block.
- R6: The data word for a beat is {bank[1:0], 6'b010110, column[7:0]}.
- R7: A READ may follow the previous command one clock later. When its first beat pair is due, it replaces any burst in progress and sends a complete burst. Until then the earlier burst keeps going. With BL 4 and CL 3, READ A in cycle 0 and READ B in cycle 1 give a0,a1 in cycle 3, b0,b1 in cycle 4 and b2,b3 in cycle 5.
- R8: A BURST STOP sampled in cycle t, with CL taken from its own `casLat`, makes `beatValid` 0 and `driveEn` 0 from cycle t+CL on, until a later READ's data begins.
- R9: When two commands land on the same start cycle, which happens when a later command uses a shorter CL, the later command wins.
- R10: In any cycle with no burst beat to send, `beatValid` is 0, `driveEn` is 0 and both data buses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command is present this cycle |
| cmdIsStop | input | 1 | 1 = BURST STOP, 0 = READ |
| cmdBank | input | 2 | Bank of a READ |
| cmdCol | input | 8 | Starting column of a READ |
| casLat | input | 2 | CAS latency code for this command |
| blSel | input | 2 | Burst length code for this command |
| doutRise | output | 16 | Beat sent in the rising half |
| doutFall | output | 16 | Beat sent in the falling half |
| beatValid | output | 2 | Valid flag per half: bit 0 rising, bit 1 falling |
| driveEn | output | 1 | Data drivers enabled |

## Verification
The hardest case to reach is two commands that land on the same start cycle. At a fixed latency every command gets its own slot, so this only happens when a CL 3 command is followed one clock later by a CL 2 command. The bench issues that pair directly, and also builds chains of READs one clock apart at both latencies, with STOPs mixed in among them. A reference model keyed by absolute cycle number predicts the two beats of every cycle.

// File: rtl/ddrrd_pkg.sv
package ddrrd_pkg;

  localparam int BANK_W = 2;
  localparam int COL_W  = 8;
  localparam int DATA_W = 16;
  localparam int PAD_W  = DATA_W - BANK_W - COL_W;
  localparam logic [PAD_W-1:0] PAD_BITS = PAD_W'(6'b010110);

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_READ = 2'd1,
    OP_STOP = 2'd2
  } op_e;

  // One landing slot of the latency line
  typedef struct packed {
    op_e               op;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
    logic [3:0]        blen;
  } slot_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic              load;
    logic              adv;
    logic              halt;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
    logic [COL_W-1:0]  mask;
  } strobe_t;

  function automatic logic [3:0] blenOf(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd2;
      2'd1:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [COL_W-1:0] beatCol(input logic [COL_W-1:0] col,
                                               input logic [COL_W-1:0] mask,
                                               input logic [COL_W-1:0] k);
    return (col & ~mask) | ((col + k) & mask);
  endfunction

  function automatic logic [DATA_W-1:0] wordOf(input logic [BANK_W-1:0] bank,
                                               input logic [COL_W-1:0] col);
    return {bank, PAD_BITS, col};
  endfunction

endpackage

// File: rtl/ddrrd_ctrl.sv
module ddrrd_ctrl
  import ddrrd_pkg::*;
#(
  parameter int MIN_CL    = 2,
  parameter int MAX_CL    = 3,
  parameter int MAX_BLEN  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdIsStop,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [COL_W-1:0]  cmdCol,
  input  logic [1:0]        casLat,
  input  logic [1:0]        blSel,
  output strobe_t           strb
);

  localparam int DEPTH  = MAX_CL - 1;
  localparam int PAIR_W = $clog2(MAX_BLEN / 2);

  slot_t dly [DEPTH];
  slot_t newSlot;
  slot_t head;
  logic [1:0] latEff;
  logic [1:0] slotIdx;
  logic [PAIR_W-1:0] pairsLeft;

  always_comb begin
    if (casLat < 2'(MIN_CL))      latEff = 2'(MIN_CL);
    else if (casLat > 2'(MAX_CL)) latEff = 2'(MAX_CL);
    else                          latEff = casLat;
    slotIdx      = latEff - 2'd2;
    newSlot.op   = cmdIsStop ? OP_STOP : OP_READ;
    newSlot.bank = cmdBank;
    newSlot.col  = cmdCol;
    newSlot.blen = blenOf(blSel);
  end

  // Latency line: stage g is consumed g+1 cycles after it is written
  for (genvar g = 0; g < DEPTH; g++) begin : gStage
    if (g == DEPTH - 1) begin : gLast
      always_ff @(posedge clk) begin
        if (!rstN) dly[g] <= '0;
        else       dly[g] <= (cmdValid && slotIdx == 2'(g)) ? newSlot : '0;
      end
    end else begin : gMid
      always_ff @(posedge clk) begin
        if (!rstN) dly[g] <= '0;
        else       dly[g] <= (cmdValid && slotIdx == 2'(g)) ? newSlot : dly[g+1];
      end
    end
  end

  assign head = dly[0];

  always_ff @(posedge clk) begin
    if (!rstN)                    pairsLeft <= '0;
    else if (head.op == OP_READ)  pairsLeft <= PAIR_W'((head.blen >> 1) - 4'd1);
    else if (head.op == OP_STOP)  pairsLeft <= '0;
    else if (pairsLeft != '0)     pairsLeft <= pairsLeft - 1'b1;
  end

  always_comb begin
    strb.load = (head.op == OP_READ);
    strb.adv  = (head.op == OP_NONE) && (pairsLeft != '0);
    strb.halt = (head.op == OP_STOP);
    strb.bank = head.bank;
    strb.col  = head.col;
    strb.mask = COL_W'(head.blen - 4'd1);
  end

  // R2: a CL-2 read is at the head one cycle after it is sampled
  a_r2_lat2_head: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdIsStop && latEff == 2'd2) |=> (head.op == OP_READ));

  // R2: a CL-3 read reaches the head two cycles later unless a CL-2 command overrides it (R9)
  a_r2_lat3_head: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdIsStop && latEff == 2'd3) ##1 !(cmdValid && latEff == 2'd2)
      |=> (head.op == OP_READ));

  // R4: an idle head lets the burst count down by one pair per cycle
  a_r4_count_down: assert property (@(posedge clk) disable iff (!rstN)
    (head.op == OP_NONE && pairsLeft != '0) |=> (pairsLeft == PAIR_W'($past(pairsLeft) - 1'b1)));

  // R8: a stop at the head leaves no pairs outstanding
  a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    (head.op == OP_STOP) |=> (pairsLeft == '0));

endmodule

// File: rtl/ddrrd_dpath.sv
module ddrrd_dpath
  import ddrrd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  output logic [DATA_W-1:0] doutRise,
  output logic [DATA_W-1:0] doutFall,
  output logic [1:0]        beatValid,
  output logic              driveEn
);

  logic [BANK_W-1:0] bankR;
  logic [COL_W-1:0]  colR;
  logic [COL_W-1:0]  maskR;
  logic [COL_W-1:0]  idx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankR     <= '0;
      colR      <= '0;
      maskR     <= '0;
      idx       <= '0;
      doutRise  <= '0;
      doutFall  <= '0;
      beatValid <= '0;
      driveEn   <= 1'b0;
    end else if (strb.load) begin
      bankR     <= strb.bank;
      colR      <= strb.col;
      maskR     <= strb.mask;
      idx       <= COL_W'(2);
      doutRise  <= wordOf(strb.bank, beatCol(strb.col, strb.mask, COL_W'(0)));
      doutFall  <= wordOf(strb.bank, beatCol(strb.col, strb.mask, COL_W'(1)));
      beatValid <= 2'b11;
      driveEn   <= 1'b1;
    end else if (strb.adv) begin
      idx       <= idx + COL_W'(2);
      doutRise  <= wordOf(bankR, beatCol(colR, maskR, idx));
      doutFall  <= wordOf(bankR, beatCol(colR, maskR, idx + COL_W'(1)));
      beatValid <= 2'b11;
      driveEn   <= 1'b1;
    end else begin
      doutRise  <= '0;
      doutFall  <= '0;
      beatValid <= '0;
      driveEn   <= 1'b0;
    end
  end

  // R3: a start or an advance drives a full pair next cycle
  a_r3_pair_driven: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load || strb.adv) |=> (beatValid == 2'b11 && driveEn));

  // R8: a stop at the head releases the bus next cycle
  a_r8_stop_release: assert property (@(posedge clk) disable iff (!rstN)
    strb.halt |=> (beatValid == 2'b00 && !driveEn));

  // R10: with nothing to send the outputs are quiet
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load || strb.adv) |=> (doutRise == '0 && doutFall == '0 && !driveEn));

  // R5: an advanced beat stays inside the block of the burst it belongs to
  a_r5_in_block: assert property (@(posedge clk) disable iff (!rstN)
    (strb.adv && !strb.load) |=> ((doutRise[COL_W-1:0] & ~maskR) == (colR & ~maskR)));

endmodule

// File: rtl/ddrrd_seq.sv
module ddrrd_seq
  import ddrrd_pkg::*;
#(
  parameter int MIN_CL   = 2,
  parameter int MAX_CL   = 3,
  parameter int MAX_BLEN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdIsStop,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [COL_W-1:0]  cmdCol,
  input  logic [1:0]        casLat,
  input  logic [1:0]        blSel,
  output logic [DATA_W-1:0] doutRise,
  output logic [DATA_W-1:0] doutFall,
  output logic [1:0]        beatValid,
  output logic              driveEn
);

  strobe_t strb;

  ddrrd_ctrl #(
    .MIN_CL   (MIN_CL),
    .MAX_CL   (MAX_CL),
    .MAX_BLEN (MAX_BLEN)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdIsStop (cmdIsStop),
    .cmdBank   (cmdBank),
    .cmdCol    (cmdCol),
    .casLat    (casLat),
    .blSel     (blSel),
    .strb      (strb)
  );

  ddrrd_dpath uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .doutRise  (doutRise),
    .doutFall  (doutFall),
    .beatValid (beatValid),
    .driveEn   (driveEn)
  );

endmodule

// File: tb/ddrrd_seq_test.sv
module ddrrd_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdIsStop = 1'b0;
  logic [1:0]  cmdBank = '0;
  logic [7:0]  cmdCol = '0;
  logic [1:0]  casLat = 2'd2;
  logic [1:0]  blSel = 2'd0;
  logic [15:0] doutRise, doutFall;
  logic [1:0]  beatValid;
  logic        driveEn;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  string curReq = "R1";

  int schedCyc  [NSLOT];
  int schedOp   [NSLOT];
  int schedBank [NSLOT];
  int schedCol  [NSLOT];
  int schedBl   [NSLOT];
  logic [15:0] expQ [$];

  ddrrd_seq uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdIsStop(cmdIsStop),
    .cmdBank(cmdBank), .cmdCol(cmdCol), .casLat(casLat), .blSel(blSel),
    .doutRise(doutRise), .doutFall(doutFall), .beatValid(beatValid), .driveEn(driveEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  function automatic logic [15:0] expWord(input int bank, input int col);
    return {bank[1:0], 6'b010110, col[7:0]};
  endfunction

  task automatic report(input logic [15:0] gr, input logic [15:0] gf, input logic [1:0] gv,
                        input logic gd, input logic [15:0] er, input logic [15:0] ef,
                        input logic [1:0] ev, input logic ed);
    checks++;
    if (gr !== er || gf !== ef || gv !== ev || gd !== ed) begin
      failures++;
      $display("FAIL %s cycle %0d: got rise=%h fall=%h valid=%b drive=%b expected rise=%h fall=%h valid=%b drive=%b",
               curReq, cyc, gr, gf, gv, gd, er, ef, ev, ed);
    end
  endtask

  // Reference model: start cycles keyed by absolute cycle, later writes win
  task automatic compareNow();
    int s;
    logic [15:0] er, ef;
    s = cyc % NSLOT;
    if (schedCyc[s] == cyc) begin
      if (schedOp[s] == 1) begin
        expQ.delete();
        for (int k = 0; k < schedBl[s]; k++)
          expQ.push_back(expWord(schedBank[s],
            (schedCol[s] & ~(schedBl[s]-1)) | ((schedCol[s] + k) & (schedBl[s]-1))));
      end else begin
        expQ.delete();
      end
      schedCyc[s] = -1;
    end
    if (expQ.size() >= 2) begin
      er = expQ.pop_front();
      ef = expQ.pop_front();
      report(doutRise, doutFall, beatValid, driveEn, er, ef, 2'b11, 1'b1);
    end else begin
      report(doutRise, doutFall, beatValid, driveEn, 16'h0, 16'h0, 2'b00, 1'b0);
    end
  endtask

  task automatic step(input bit v, input bit stop, input int bank, input int col,
                      input int lat, input int bl);
    int effLat, s;
    @(negedge clk);
    compareNow();
    cmdValid  = v;
    cmdIsStop = stop;
    cmdBank   = bank[1:0];
    cmdCol    = col[7:0];
    casLat    = lat[1:0];
    blSel     = (bl == 2) ? 2'd0 : (bl == 4) ? 2'd1 : (bl == 8) ? 2'd2 : 2'd3;
    if (v) begin
      effLat = (lat == 3) ? 3 : 2;
      s = (cyc + effLat) % NSLOT;
      schedCyc[s]  = cyc + effLat;
      schedOp[s]   = stop ? 2 : 1;
      schedBank[s] = bank;
      schedCol[s]  = col;
      schedBl[s]   = (bl == 2 || bl == 4) ? bl : 8;
    end
  endtask

  task automatic rd(input int bank, input int col, input int lat, input int bl);
    step(1'b1, 1'b0, bank, col, lat, bl);
  endtask

  task automatic stp(input int lat);
    step(1'b1, 1'b1, 0, 0, lat, 2);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, 0, 2, 2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NSLOT; i++) schedCyc[i] = -1;
    repeat (3) @(negedge clk);
    curReq = "R1";
    report(doutRise, doutFall, beatValid, driveEn, 16'h0, 16'h0, 2'b00, 1'b0);
    rstN = 1'b1;
    idle(2);

    curReq = "R2"; rd(1, 8'h10, 3, 4); idle(6);
    curReq = "R2"; rd(2, 8'h20, 2, 4); idle(5);
    curReq = "R2"; rd(3, 8'h30, 0, 2); idle(4);   // code 0 clamps to CL 2
    curReq = "R3"; rd(0, 8'h44, 2, 8); idle(7);
    curReq = "R4"; rd(1, 8'h08, 3, 2); idle(4);
    curReq = "R4"; rd(2, 8'h50, 2, 0); idle(7);   // code 3 gives BL 8
    curReq = "R5"; rd(1, 8'h05, 2, 8); idle(7);
    curReq = "R5"; rd(3, 8'hFB, 3, 4); idle(6);
    curReq = "R6"; rd(2, 8'hA7, 2, 2); idle(4);

    curReq = "R7"; rd(0, 8'h00, 3, 4); rd(1, 8'h40, 3, 4); idle(7);
    curReq = "R7";
    rd(0, 8'h10, 2, 8); rd(1, 8'h20, 2, 8); rd(2, 8'h30, 2, 8); rd(3, 8'h3E, 2, 8);
    idle(8);
    curReq = "R7"; rd(2, 8'h60, 3, 8); idle(2); rd(3, 8'h71, 3, 8); idle(8);

    curReq = "R8"; rd(1, 8'h80, 3, 8); stp(3); idle(8);
    curReq = "R8"; rd(1, 8'h90, 2, 8); idle(1); stp(2); idle(6);
    curReq = "R8"; stp(2); rd(0, 8'hC0, 2, 4); idle(5);

    curReq = "R9"; rd(1, 8'hD0, 3, 8); rd(2, 8'hE4, 2, 4); idle(8);
    curReq = "R9"; rd(3, 8'h12, 3, 8); stp(2); idle(8);

    curReq = "R10"; idle(6);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule